// File: doc/BRIEF.md
# Register Access Bridge Command Decoder

This block sits behind a CAN FD controller and turns the byte payload of each received frame into accesses on an internal register port. It then builds the payload of the reply frame. A request starts with a command byte that gives the direction and the byte count. Two address bytes follow, high byte first. A write request then carries its data bytes. For a write, the block issues one register write per data byte. For a read, it fetches the requested bytes and places them after a two-byte reply header.

One address is special: the FIFO data address. A burst that starts on that address keeps reading from the FIFO, or writing to it, for every byte, and the address does not advance. A read burst that starts elsewhere and walks across the FIFO address gets a zero byte for that position, and the FIFO is not popped. The reply is padded with zeros up to the next legal CAN FD payload length. The matching 4-bit DLC code is driven beside the reply bytes.

Top module: `rab_bridge_top`

## Requirements
- R1: Command bit 6 set means read and clear means write; bits 5:0 give the byte count; bit 7 has no effect on behaviour.
- R2: Address byte 1 is the high byte and byte 2 the low byte. Each write data byte within the count produces one `reg_wr_en` pulse, one cycle after the byte, carrying that byte. Its address starts at the request address and rises by one per byte. `reg_wr_en` and `reg_rd_en` are never high together.
- R3: Request bytes beyond command byte + 2 address bytes + count cause no register write.
- R4: Every reply starts with an echo of the received command byte, then a status byte. The status is 0x01 when the request is complete. A write reply carries no other data bytes.
- R5: After the two header bytes, a read reply carries count data bytes, read from consecutive addresses starting at the request address.
- R6: A burst whose start address equals FIFO_ADDR (default 0x1010) never advances its address. Every byte of the burst is a FIFO pop (read) or a FIFO push (write).
- R7: In a read burst that does not start on FIFO_ADDR, the byte at FIFO_ADDR is returned as 0x00 and no read strobe is issued for it.
- R8: The reply is streamed one byte per cycle with `rsp_valid` high and no gaps, and `rsp_last` marks the final byte. Its length is the smallest value in {0..8, 12, 16, 20, 24, 32, 48, 64} that is at least the needed length, and pad bytes are 0x00. `rsp_dlc` holds the matching code during the whole reply: 0..8 for lengths up to 8, then 9..15 for 12, 16, 20, 24, 32, 48 and 64.
- R9: Some requests get status 0x02 and only the two header bytes. This covers a request of fewer than 3 bytes, a write with fewer data bytes than its count, and a read whose count exceeds 62.
- R10: Request bytes presented while a reply is being streamed are ignored.
- R11: After reset, `rsp_valid`, `reg_wr_en` and `reg_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request payload byte present |
| req_data | input | 8 | Request payload byte |
| req_last | input | 1 | Final byte of the received payload, pad included |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 16 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | Register read strobe; a read strobe at FIFO_ADDR pops the FIFO |
| reg_rd_addr | output | 16 | Register read address |
| reg_rd_data | input | 8 | Read data, valid in the same cycle as the strobe |
| rsp_valid | output | 1 | Reply byte present |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final reply byte |
| rsp_dlc | output | 4 | CAN FD DLC code of the reply length |

## Verification
The assertions assume two things about the environment. First, the register port answers a read in the same cycle as the strobe. Second, a payload never exceeds 64 bytes, so the received-byte counter never saturates. The stimulus keeps every frame within 64 bytes and models the register side as a zero-latency stub. In that stub, ordinary addresses return a fixed function of the address, and the FIFO address is a byte queue. Bytes sent during a reply are limited to two, so they always fall inside the shortest possible reply.

// File: rtl/rab_pkg.sv
package rab_pkg;
    localparam int RAB_AW  = 16;
    localparam int RAB_LW  = 7;
    localparam int RAB_MAX_RD = 62;
    localparam logic [7:0] RAB_ST_OK  = 8'h01;
    localparam logic [7:0] RAB_ST_ERR = 8'h02;

    typedef enum logic [0:0] {ST_RX, ST_RSP} rab_st_e;

    typedef struct packed {
        rab_st_e           st;
        logic [7:0]        cmd;
        logic [RAB_AW-1:0] addr;
        logic              fifo_mode;
        logic [RAB_LW-1:0] cnt;
        logic              ok;
        logic [RAB_LW-1:0] idx;
        logic [RAB_LW-1:0] need;
        logic [RAB_LW-1:0] len;
        logic [3:0]        dlc;
        logic              wr_en;
        logic [RAB_AW-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              rsp_valid;
        logic [7:0]        rsp_data;
        logic              rsp_last;
    } rab_state_t;
endpackage

// File: rtl/rab_len_round.sv
module rab_len_round
    import rab_pkg::*;
(
    input  logic [RAB_LW-1:0] need,
    output logic [RAB_LW-1:0] len,
    output logic [3:0]        dlc
);
    always_comb begin
        if (need <= 7'd8) begin
            len = need;
            dlc = need[3:0];
        end else if (need <= 7'd12) begin
            len = 7'd12; dlc = 4'd9;
        end else if (need <= 7'd16) begin
            len = 7'd16; dlc = 4'd10;
        end else if (need <= 7'd20) begin
            len = 7'd20; dlc = 4'd11;
        end else if (need <= 7'd24) begin
            len = 7'd24; dlc = 4'd12;
        end else if (need <= 7'd32) begin
            len = 7'd32; dlc = 4'd13;
        end else if (need <= 7'd48) begin
            len = 7'd48; dlc = 4'd14;
        end else begin
            len = 7'd64; dlc = 4'd15;
        end
    end
endmodule

// File: rtl/rab_rd_gate.sv
module rab_rd_gate
    import rab_pkg::*;
#(
    parameter logic [RAB_AW-1:0] FIFO_ADDR = 16'h1010
) (
    input  logic              in_data,
    input  logic [RAB_AW-1:0] addr,
    input  logic              fifo_mode,
    input  logic [7:0]        rd_data,
    output logic              rd_en,
    output logic [7:0]        rd_byte
);
    // A burst that only passes over the FIFO address must not pop it.
    always_comb begin
        rd_en   = in_data && ((addr != FIFO_ADDR) || fifo_mode);
        rd_byte = rd_en ? rd_data : 8'h00;
    end
endmodule

// File: rtl/rab_bridge_top.sv
module rab_bridge_top
    import rab_pkg::*;
#(
    parameter logic [RAB_AW-1:0] FIFO_ADDR = 16'h1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_data,
    input  logic              req_last,
    output logic              reg_wr_en,
    output logic [RAB_AW-1:0] reg_wr_addr,
    output logic [7:0]        reg_wr_data,
    output logic              reg_rd_en,
    output logic [RAB_AW-1:0] reg_rd_addr,
    input  logic [7:0]        reg_rd_data,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_last,
    output logic [3:0]        rsp_dlc
);
    localparam logic [RAB_LW-1:0] HDR_LEN = 7'd3;
    localparam logic [RAB_LW-1:0] CNT_SAT = {RAB_LW{1'b1}};

    rab_state_t q, d;

    logic [RAB_LW-1:0] cnt_n, data_rx, need_c, len_c;
    logic [3:0]        dlc_c;
    logic [7:0]        cmd_now;
    logic              ok_c;
    logic              in_data;
    logic [7:0]        rd_byte;

    // Completion check of the request that ends with the current byte.
    always_comb begin
        cnt_n   = (q.cnt == CNT_SAT) ? q.cnt : q.cnt + 7'd1;
        cmd_now = (q.cnt == '0) ? req_data : q.cmd;
        data_rx = (cnt_n >= HDR_LEN) ? cnt_n - HDR_LEN : '0;
        ok_c    = (cnt_n >= HDR_LEN) &&
                  (cmd_now[6] ? ({1'b0, cmd_now[5:0]} <= 7'(RAB_MAX_RD))
                              : (data_rx >= {1'b0, cmd_now[5:0]}));
        need_c  = (ok_c && cmd_now[6]) ? 7'd2 + {1'b0, cmd_now[5:0]} : 7'd2;
    end

    rab_len_round u_round (
        .need (need_c),
        .len  (len_c),
        .dlc  (dlc_c)
    );

    assign in_data = (q.st == ST_RSP) && q.cmd[6] && q.ok &&
                     (q.idx >= 7'd2) && (q.idx < q.need);

    rab_rd_gate #(.FIFO_ADDR(FIFO_ADDR)) u_gate (
        .in_data   (in_data),
        .addr      (q.addr),
        .fifo_mode (q.fifo_mode),
        .rd_data   (reg_rd_data),
        .rd_en     (reg_rd_en),
        .rd_byte   (rd_byte)
    );

    always_comb begin
        d           = q;
        d.wr_en     = 1'b0;
        d.rsp_valid = 1'b0;
        d.rsp_last  = 1'b0;
        d.rsp_data  = 8'h00;
        unique case (q.st)
            ST_RX: begin
                if (req_valid) begin
                    d.cnt = cnt_n;
                    if (q.cnt == 7'd0) begin
                        d.cmd       = req_data;
                        d.addr      = '0;
                        d.fifo_mode = 1'b0;
                    end else if (q.cnt == 7'd1) begin
                        d.addr[15:8] = req_data;
                    end else if (q.cnt == 7'd2) begin
                        d.addr      = {q.addr[15:8], req_data};
                        d.fifo_mode = ({q.addr[15:8], req_data} == FIFO_ADDR);
                    end else if (!q.cmd[6] &&
                                 ((q.cnt - HDR_LEN) < {1'b0, q.cmd[5:0]})) begin
                        d.wr_en   = 1'b1;
                        d.wr_addr = q.addr;
                        d.wr_data = req_data;
                        if (!q.fifo_mode) d.addr = q.addr + 16'd1;
                    end
                    if (req_last) begin
                        d.st   = ST_RSP;
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.ok   = ok_c;
                        d.need = need_c;
                        d.len  = len_c;
                        d.dlc  = dlc_c;
                    end
                end
            end
            ST_RSP: begin
                d.rsp_valid = 1'b1;
                d.idx       = q.idx + 7'd1;
                d.rsp_last  = (q.idx == q.len - 7'd1);
                if (q.idx == 7'd0)      d.rsp_data = q.cmd;
                else if (q.idx == 7'd1) d.rsp_data = q.ok ? RAB_ST_OK : RAB_ST_ERR;
                else if (in_data) begin
                    d.rsp_data = rd_byte;
                    if (!q.fifo_mode) d.addr = q.addr + 16'd1;
                end
                if (q.idx == q.len - 7'd1) d.st = ST_RX;
            end
            default: d.st = ST_RX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RX;
        end else begin
            q <= d;
        end
    end

    assign reg_wr_en   = q.wr_en;
    assign reg_wr_addr = q.wr_addr;
    assign reg_wr_data = q.wr_data;
    assign reg_rd_addr = q.addr;
    assign rsp_valid   = q.rsp_valid;
    assign rsp_data    = q.rsp_data;
    assign rsp_last    = q.rsp_last;
    assign rsp_dlc     = q.dlc;

    p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    p_fifo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && q.fifo_mode) |-> (reg_rd_addr == FIFO_ADDR));

    p_skip_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !q.fifo_mode && reg_rd_addr == FIFO_ADDR) |=> (rsp_data == 8'h00));

    p_contig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    p_dlc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> $stable(rsp_dlc));

    p_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RSP && $past(q.st) == ST_RSP) |-> !reg_wr_en);
endmodule

// File: tb/rab_bridge_top_tb_top.sv
module rab_bridge_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] FIFO_A = 16'h1010;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_data = 8'h00;
    logic        req_last = 1'b0;
    logic        reg_wr_en, reg_rd_en;
    logic [15:0] reg_wr_addr, reg_rd_addr;
    logic [7:0]  reg_wr_data, reg_rd_data;
    logic        rsp_valid, rsp_last;
    logic [7:0]  rsp_data;
    logic [3:0]  rsp_dlc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rab_bridge_top #(.FIFO_ADDR(FIFO_A)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_data(req_data), .req_last(req_last),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .rsp_dlc(rsp_dlc)
    );

    // Register-side stub: plain addresses return addr^0x5A, FIFO is a ring.
    logic [7:0] stub_mem [0:255];
    int stub_wp = 0;
    int stub_rp = 0;
    always_comb begin
        if (reg_rd_addr == FIFO_A)
            reg_rd_data = (stub_rp == stub_wp) ? 8'h00 : stub_mem[stub_rp[7:0]];
        else
            reg_rd_data = reg_rd_addr[7:0] ^ 8'h5A;
    end
    always @(posedge clk) begin
        if (rst_n && reg_wr_en && reg_wr_addr == FIFO_A) begin
            stub_mem[stub_wp[7:0]] <= reg_wr_data;
            stub_wp <= stub_wp + 1;
        end
        if (rst_n && reg_rd_en && reg_rd_addr == FIFO_A && stub_rp != stub_wp)
            stub_rp <= stub_rp + 1;
    end

    // Reference model state.
    logic [7:0]  exp_rsp [$];
    logic        exp_lst [$];
    logic [3:0]  exp_dlc [$];
    logic [23:0] exp_wr  [$];
    logic [7:0]  m_fifo  [$];
    string       cur_req = "R11";

    int n_vec = 0;
    int n_err = 0;
    int cyc = 0;

    function automatic void round_len(input int need, output int len, output int code);
        if (need <= 8) begin len = need; code = need; end
        else if (need <= 12) begin len = 12; code = 9; end
        else if (need <= 16) begin len = 16; code = 10; end
        else if (need <= 20) begin len = 20; code = 11; end
        else if (need <= 24) begin len = 24; code = 12; end
        else if (need <= 32) begin len = 32; code = 13; end
        else if (need <= 48) begin len = 48; code = 14; end
        else begin len = 64; code = 15; end
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) check({cur_req, " unexpected reply byte"}, 1, 0);
                else begin
                    check({cur_req, " R4 R5 reply byte"}, rsp_data, exp_rsp.pop_front());
                    check({cur_req, " R8 last flag"}, rsp_last, exp_lst.pop_front());
                    check({cur_req, " R8 dlc"}, rsp_dlc, exp_dlc.pop_front());
                end
            end
            if (reg_wr_en) begin
                if (exp_wr.size() == 0) check({cur_req, " R3 unexpected write"}, {reg_wr_addr, reg_wr_data}, 0);
                else check({cur_req, " R2 write addr/data"}, {reg_wr_addr, reg_wr_data}, exp_wr.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    // Builds the expected effects of one received payload, then sends it.
    task automatic send(input string tag, input logic [7:0] p [$], input bit junk);
        int L = p.size();
        logic [7:0] cmd = p[0];
        int cnt = int'(cmd[5:0]);
        bit rd = cmd[6];
        logic [15:0] a = 16'h0;
        logic [15:0] start;
        bit ok;
        int need, len, code, nwr;
        logic [7:0] rbytes [$];
        cur_req = tag;
        if (L >= 3) a = {p[1], p[2]};
        start = a;
        nwr = 0;
        if (!rd && L > 3) nwr = (L - 3 < cnt) ? L - 3 : cnt;
        for (int i = 0; i < nwr; i++) begin
            exp_wr.push_back({a, p[3+i]});
            if (a == FIFO_A) m_fifo.push_back(p[3+i]);
            if (start != FIFO_A) a = a + 16'd1;
        end
        ok = (L >= 3) && (rd ? (cnt <= 62) : (L - 3 >= cnt));
        need = (ok && rd) ? 2 + cnt : 2;
        round_len(need, len, code);
        a = start;
        if (ok && rd) begin
            for (int k = 0; k < cnt; k++) begin
                if (a == FIFO_A) begin
                    if (start == FIFO_A) rbytes.push_back(m_fifo.size() ? m_fifo.pop_front() : 8'h00);
                    else rbytes.push_back(8'h00);
                end else rbytes.push_back(a[7:0] ^ 8'h5A);
                if (start != FIFO_A) a = a + 16'd1;
            end
        end
        for (int j = 0; j < len; j++) begin
            logic [7:0] b;
            if (j == 0) b = cmd;
            else if (j == 1) b = ok ? 8'h01 : 8'h02;
            else if (j - 2 < rbytes.size()) b = rbytes[j-2];
            else b = 8'h00;
            exp_rsp.push_back(b);
            exp_lst.push_back(j == len - 1);
            exp_dlc.push_back(4'(code));
        end
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_data = p[i]; req_last = (i == L - 1);
        end
        if (junk) begin
            // R10: two bytes land while the reply is being streamed.
            @(negedge clk); req_valid = 1'b1; req_data = 8'h03; req_last = 1'b0;
            @(negedge clk); req_valid = 1'b1; req_data = 8'h10; req_last = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0; req_last = 1'b0;
        while (exp_rsp.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check({tag, " reply complete"}, exp_rsp.size() + exp_wr.size(), 0);
    endtask

    initial begin
        logic [7:0] p [$];
        repeat (3) @(negedge clk);
        check("R11 rsp_valid after reset", rsp_valid, 0);
        check("R11 reg_wr_en after reset", reg_wr_en, 0);
        check("R11 reg_rd_en after reset", reg_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6 R3: 12-byte FIFO write burst plus one pad byte.
        p = '{8'h0C, 8'h10, 8'h10, 8'h82, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44,
              8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 8'h00};
        send("R6 fifo write", p, 0);
        // R7: burst passes over the FIFO address, zero and no pop.
        p = '{8'h43, 8'h10, 8'h0F};
        send("R7 skip fifo", p, 0);
        // R6 R8: 12-byte FIFO read, reply 14 rounded to 16.
        p = '{8'h4C, 8'h10, 8'h10};
        send("R6 fifo read", p, 0);
        // R3: pad bytes beyond count write nothing.
        p = '{8'h05, 8'h00, 8'h20, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hEE, 8'hEE, 8'hEE, 8'hEE};
        send("R3 ignored pad", p, 0);
        // R9: write with too few data bytes.
        p = '{8'h05, 8'h00, 8'h40, 8'h01, 8'h02};
        send("R9 short write", p, 0);
        // R9: read count too large, and a 2-byte request.
        p = '{8'h7F, 8'h00, 8'h00};
        send("R9 oversize read", p, 0);
        p = '{8'h41, 8'h00};
        send("R9 short header", p, 0);
        // R5 R8: 7-byte plain read, reply 9 rounded to 12.
        p = '{8'h47, 8'h01, 8'h00};
        send("R5 plain read", p, 0);
        // R8: 62-byte read fills a 64-byte reply.
        p = '{8'h7E, 8'h02, 8'h00};
        send("R8 max read", p, 0);
        // R1: bit 7 set has no effect on a write.
        p = '{8'h83, 8'h12, 8'h34, 8'hC1, 8'hC2, 8'hC3};
        send("R1 bit7 write", p, 0);
        // R10: junk during reply, then a normal request parses cleanly.
        p = '{8'h42, 8'h00, 8'h30};
        send("R10 junk", p, 1);
        p = '{8'h44, 8'h00, 8'h31};
        send("R10 after junk", p, 0);
        // R6: FIFO read after drain returns zeros; R4 write of 3 to the FIFO.
        p = '{8'h03, 8'h10, 8'h10, 8'h5A, 8'h6B, 8'h7C};
        send("R4 fifo push", p, 0);
        p = '{8'h45, 8'h10, 8'h10};
        send("R6 fifo drain", p, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule